// File: doc/BRIEF.md
# Anticollision UID Prefix Responder

This block answers the tree-walking inventory round of a contactless tag. A reader that has seen a collision on bit position k of the identifier sends a command holding a 5-bit prefix length k (most significant bit first), then the first k identifier bits it has resolved, then eight CRC bits. The block compares each prefix bit against the tag's own 32-bit identifier as it arrives. A running mismatch flag is kept, so no wide comparator is needed at the end of the frame. When the frame ends with a good CRC verdict and every prefix bit matched, the block queues a reply: one start-of-frame beat followed by identifier positions k+1 through 32.

The same serializer also answers a plain identifier request, strobed by the upstream command decoder, with the start-of-frame beat and all 32 identifier bits. Received bits come in one per cycle with a valid strobe. The end of a frame is a separate strobe that carries the CRC verdict computed upstream. Reply beats leave through a ready/valid handshake toward a line encoder, which handles the anticollision coding. The block neither generates nor checks CRC itself.

Top module: `acr_uid_responder`

## Requirements
- R1: After frame end, the first 5 received bits are the prefix length k, most significant bit first. The next k bits are the prefix. Any further bits (the CRC field) take no part in the comparison.
- R2: When all k prefix bits equal identifier positions 1..k and the CRC verdict is good, the reply is 33−k beats: a start-of-frame beat (tx_sof=1, tx_bit=0), then positions k+1..32 in order, with tx_last set on the final beat. For k=31 this is the start-of-frame beat and one data beat.
- R3: A prefix that differs from the identifier in any single bit, including the last prefix bit, produces no reply beat at all.
- R4: A frame that ends with rx_crc_ok low produces no reply, even if the prefix matches.
- R5: k=0 matches every identifier and yields the start-of-frame beat plus all 32 identifier bits.
- R6: Air order: identifier byte UID0 = uid[7:0] goes first, then uid[15:8], uid[23:16] and uid[31:24], each byte most significant bit first. Position N=1 is uid[7], and N=9 is uid[15].
- R7: A pulse on rx_req while no reply is in progress yields the start-of-frame beat followed by all 32 identifier bits in R6 order.
- R8: While tx_valid is high and tx_ready is low, tx_bit, tx_sof and tx_last hold their values. tx_sof is set only on the first beat of a reply. tx_valid falls in the cycle after the beat carrying tx_last is accepted.
- R9: A frame that ends before 5+k bits have arrived produces no reply.
- R10: While a reply is in progress, received bits, frame ends and rx_req are ignored. A frame that receives any bit during a reply produces no reply, and the running reply completes in full.
- R11: After reset, tx_valid is low, and the parser expects a new prefix-length field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uid | input | 32 | Tag identifier, byte UID0 in bits 7:0 |
| rx_valid | input | 1 | A received command bit is present on rx_bit |
| rx_bit | input | 1 | Received command bit |
| rx_eof | input | 1 | End of the current command frame |
| rx_crc_ok | input | 1 | CRC verdict for the frame, sampled with rx_eof |
| rx_req | input | 1 | Pulse: plain identifier request decoded |
| tx_ready | input | 1 | Line encoder accepts the current beat |
| tx_valid | output | 1 | A reply beat is offered |
| tx_bit | output | 1 | Reply data bit (0 on the start-of-frame beat) |
| tx_sof | output | 1 | Current beat is the start-of-frame marker |
| tx_last | output | 1 | Current beat is the final beat of the reply |

## Verification
The hardest case to reach is a frame that arrives while a reply is still draining. It needs the handshake to stall long enough for a whole command to pass. The bench holds tx_ready low for a stretch after an identifier request, sends a complete matching anticollision frame and a second request during the stall, and then releases the line encoder. Mismatches are placed on the final prefix bit of a 31-bit prefix, the one position where a late comparison could slip through. A behavioural model, fed from the same port activity, predicts every reply beat under a randomly throttled tx_ready.

// File: rtl/acr_pkg.sv
package acr_pkg;

   typedef enum logic [1:0] {
      PS_COUNT  = 2'd0,
      PS_PREFIX = 2'd1,
      PS_TAIL   = 2'd2
   } prs_state_t;

   // Air position n (0-based, n=0 is N=1) to identifier bit index:
   // bytes go low byte first, each byte high bit first.
   function automatic int unsigned air_index(input int unsigned n);
      return 8 * (n / 8) + 7 - (n % 8);
   endfunction

endpackage

// File: rtl/acr_cmd_parser.sv
module acr_cmd_parser #(
   parameter int UID_W = 32,
   parameter int K_W   = 5,
   localparam int P_W   = $clog2(UID_W + 1),
   localparam int IDX_W = $clog2(UID_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             rx_valid,
   input  logic             rx_bit,
   input  logic             rx_eof,
   input  logic             rx_crc_ok,
   input  logic [UID_W-1:0] uid_air,
   output logic             fire,
   output logic [P_W-1:0]   fire_pos
);
   import acr_pkg::*;

   prs_state_t     state_q;
   logic [K_W-1:0] cnt_q;
   logic [K_W-1:0] k_q;
   logic           miss_q;
   logic           spoil_q;
   logic [K_W-1:0] k_next;

   assign k_next = {k_q[K_W-2:0], rx_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_COUNT;
         cnt_q   <= '0;
         k_q     <= '0;
         miss_q  <= 1'b0;
         spoil_q <= 1'b0;
      end else if (rx_eof) begin
         state_q <= PS_COUNT;
         cnt_q   <= '0;
         k_q     <= '0;
         miss_q  <= 1'b0;
         spoil_q <= 1'b0;
      end else if (rx_valid) begin
         if (busy) begin
            spoil_q <= 1'b1;
         end else begin
            unique case (state_q)
               PS_COUNT: begin
                  k_q <= k_next;
                  if (cnt_q == K_W'(K_W - 1)) begin
                     cnt_q   <= '0;
                     state_q <= (k_next == '0) ? PS_TAIL : PS_PREFIX;
                  end else begin
                     cnt_q <= cnt_q + K_W'(1);
                  end
               end
               PS_PREFIX: begin
                  if (int'(cnt_q) < UID_W && rx_bit != uid_air[IDX_W'(cnt_q)])
                     miss_q <= 1'b1;
                  if (cnt_q == k_q - K_W'(1)) state_q <= PS_TAIL;
                  else                        cnt_q   <= cnt_q + K_W'(1);
               end
               default: ;
            endcase
         end
      end
   end

   assign fire = rx_eof && !busy && !spoil_q && !miss_q && rx_crc_ok
                 && (state_q == PS_TAIL);

   generate
      if ((2 ** K_W) - 1 >= UID_W) begin : g_clamp
         assign fire_pos = (int'(k_q) >= UID_W) ? P_W'(UID_W) : P_W'(k_q);
      end else begin : g_direct
         assign fire_pos = P_W'(k_q);
      end
   endgenerate

endmodule

// File: rtl/acr_reply_ser.sv
module acr_reply_ser #(
   parameter int UID_W = 32,
   localparam int P_W   = $clog2(UID_W + 1),
   localparam int IDX_W = $clog2(UID_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [P_W-1:0]   load_pos,
   input  logic [UID_W-1:0] uid_air,
   input  logic             tx_ready,
   output logic             busy,
   output logic             tx_bit,
   output logic             tx_sof,
   output logic             tx_last
);
   logic           busy_q;
   logic           sof_q;
   logic [P_W-1:0] pos_q;
   logic           take;

   assign take = busy_q && tx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sof_q  <= 1'b0;
         pos_q  <= '0;
      end else if (load && !busy_q) begin
         busy_q <= 1'b1;
         sof_q  <= 1'b1;
         pos_q  <= load_pos;
      end else if (take) begin
         if (sof_q) begin
            sof_q <= 1'b0;
            if (pos_q == P_W'(UID_W)) busy_q <= 1'b0;
         end else begin
            if (pos_q == P_W'(UID_W - 1)) busy_q <= 1'b0;
            pos_q <= pos_q + P_W'(1);
         end
      end
   end

   assign busy    = busy_q;
   assign tx_sof  = sof_q;
   assign tx_bit  = sof_q ? 1'b0 : uid_air[IDX_W'(pos_q)];
   assign tx_last = sof_q ? (pos_q == P_W'(UID_W)) : (pos_q == P_W'(UID_W - 1));

endmodule

// File: rtl/acr_uid_responder.sv
module acr_uid_responder #(
   parameter int UID_BYTES = 4,
   parameter int K_W       = 5,
   localparam int UID_W    = 8 * UID_BYTES,
   localparam int P_W      = $clog2(UID_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [UID_W-1:0] uid,
   input  logic             rx_valid,
   input  logic             rx_bit,
   input  logic             rx_eof,
   input  logic             rx_crc_ok,
   input  logic             rx_req,
   input  logic             tx_ready,
   output logic             tx_valid,
   output logic             tx_bit,
   output logic             tx_sof,
   output logic             tx_last
);
   logic [UID_W-1:0] uid_air;
   logic             busy;
   logic             fire;
   logic [P_W-1:0]   fire_pos;
   logic             load;
   logic [P_W-1:0]   load_pos;

   generate
      if (UID_BYTES < 1) begin : g_bad_bytes
         $error("UID_BYTES must be at least 1");
      end
      if (K_W < 2) begin : g_bad_kw
         $error("K_W must be at least 2");
      end
      for (genvar n = 0; n < UID_W; n++) begin : g_air
         assign uid_air[n] = uid[acr_pkg::air_index(n)];
      end
   endgenerate

   acr_cmd_parser #(.UID_W(UID_W), .K_W(K_W)) i_parser (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .rx_valid  (rx_valid),
      .rx_bit    (rx_bit),
      .rx_eof    (rx_eof),
      .rx_crc_ok (rx_crc_ok),
      .uid_air   (uid_air),
      .fire      (fire),
      .fire_pos  (fire_pos)
   );

   assign load     = fire || (rx_req && !busy);
   assign load_pos = fire ? fire_pos : '0;

   acr_reply_ser #(.UID_W(UID_W)) i_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_pos (load_pos),
      .uid_air  (uid_air),
      .tx_ready (tx_ready),
      .busy     (busy),
      .tx_bit   (tx_bit),
      .tx_sof   (tx_sof),
      .tx_last  (tx_last)
   );

   assign tx_valid = busy;

endmodule

// File: rtl/acr_uid_responder_chk.sv
module acr_uid_responder_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_eof,
   input logic rx_crc_ok,
   input logic rx_req,
   input logic tx_ready,
   input logic tx_valid,
   input logic tx_bit,
   input logic tx_sof,
   input logic tx_last
);
   // R8
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_bit) && $stable(tx_sof) && $stable(tx_last)));

   // R8
   sof_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_sof && !tx_last) |=> (tx_valid && !tx_sof));

   // R8
   end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> !tx_valid);

   // R2
   reply_opens_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> tx_sof);

   // R4
   bad_crc_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_eof && !rx_crc_ok && !rx_req && !tx_valid) |=> !tx_valid);

   // R10
   no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !(tx_ready && tx_last)) |=> tx_valid);

endmodule

bind acr_uid_responder acr_uid_responder_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_eof    (rx_eof),
   .rx_crc_ok (rx_crc_ok),
   .rx_req    (rx_req),
   .tx_ready  (tx_ready),
   .tx_valid  (tx_valid),
   .tx_bit    (tx_bit),
   .tx_sof    (tx_sof),
   .tx_last   (tx_last)
);

// File: tb/test_acr_uid_responder.sv
`timescale 1ns/1ps
module test_acr_uid_responder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] uid = 32'h9C3A_61E7;
   logic        rx_valid = 1'b0, rx_bit = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0, rx_req = 1'b0;
   logic        tx_ready = 1'b0;
   logic        tx_valid, tx_bit, tx_sof, tx_last;

   int    n_chk = 0, n_fail = 0, cyc = 0, nbeats = 0;
   string cur_req = "R11";
   bit    hold_low = 1'b0;
   logic [2:0] exq[$];
   bit    rxb[$];
   bit    m_spoil = 1'b0;

   always #2 clk = ~clk;

   acr_uid_responder i_acr_uid_responder (
      .clk(clk), .rst_n(rst_n), .uid(uid), .rx_valid(rx_valid), .rx_bit(rx_bit),
      .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .rx_req(rx_req), .tx_ready(tx_ready),
      .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_sof(tx_sof), .tx_last(tx_last));

   // R6: position n (0-based) of the air order
   function automatic bit air(input int n);
      return uid[8 * (n / 8) + 7 - (n % 8)];
   endfunction

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push_reply(input int start);
      exq.push_back({1'b1, 1'b0, start >= 32});
      for (int p = start; p < 32; p++) exq.push_back({1'b0, air(p), p == 31});
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         exq.delete(); rxb.delete(); m_spoil = 1'b0;
      end else begin
         bit busy_now;
         busy_now = (exq.size() != 0);
         if (busy_now && tx_ready) void'(exq.pop_front());
         if (rx_eof) begin
            if (!busy_now && !m_spoil && rx_crc_ok && rxb.size() >= 5) begin
               int k; bit ok;
               k = 0;
               for (int i = 0; i < 5; i++) k = k * 2 + int'(rxb[i]);
               ok = (rxb.size() >= 5 + k);
               for (int i = 0; i < k && ok; i++) if (rxb[5 + i] != air(i)) ok = 1'b0;
               if (ok) push_reply(k);
            end
            rxb.delete(); m_spoil = 1'b0;
         end else begin
            if (rx_valid) begin
               if (busy_now) m_spoil = 1'b1;
               else rxb.push_back(rx_bit);
            end
            if (rx_req && !busy_now) push_reply(0);
         end
         if (tx_valid && tx_ready) nbeats++;
      end
   end

   // compare on every clock, then throttle the line encoder
   always @(negedge clk) begin
      if (rst_n) begin
         if (exq.size() == 0)
            chk(tx_valid == 1'b0, cur_req, "tx_valid idle", int'(tx_valid), 0);
         else
            chk(tx_valid && {tx_sof, tx_bit, tx_last} == exq[0], cur_req, "beat {valid,sof,bit,last}",
                int'({tx_valid, tx_sof, tx_bit, tx_last}), int'({1'b1, exq[0]}));
      end
      tx_ready <= hold_low ? 1'b0 : (($urandom % 4) != 0);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic put_bit(input bit b);
      rx_valid = 1'b1; rx_bit = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (exq.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // npref: prefix bits sent; flip: prefix position to invert (-1 none)
   task automatic ac_frame(input int k, input int npref, input int flip, input bit crc,
                           input int exp, input string tag);
      int base;
      cur_req = tag; base = nbeats;
      for (int i = 4; i >= 0; i--) put_bit(((k >> i) & 1) != 0);
      for (int i = 0; i < npref; i++) put_bit(air(i) ^ (i == flip));
      if (npref == k) for (int i = 0; i < 8; i++) put_bit(((8'hA7 >> i) & 1) != 0);
      rx_eof = 1'b1; rx_crc_ok = crc;
      @(negedge clk);
      rx_eof = 1'b0; rx_crc_ok = 1'b0;
      wait_idle();
      chk(nbeats - base == exp, tag, "reply beat count", nbeats - base, exp);
   endtask

   initial begin
      int base;
      repeat (3) @(negedge clk);
      chk(tx_valid == 1'b0, "R11", "tx_valid in reset", int'(tx_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_valid == 1'b0, "R11", "tx_valid after reset", int'(tx_valid), 0);

      // R7 / R6: plain request
      cur_req = "R7"; base = nbeats;
      rx_req = 1'b1; @(negedge clk); rx_req = 1'b0;
      wait_idle();
      chk(nbeats - base == 33, "R7", "request beat count", nbeats - base, 33);

      ac_frame(0, 0, -1, 1'b1, 33, "R5");
      ac_frame(10, 10, -1, 1'b1, 23, "R2");
      ac_frame(9, 9, -1, 1'b1, 24, "R6");
      ac_frame(10, 10, 3, 1'b1, 0, "R3");
      ac_frame(31, 31, 30, 1'b1, 0, "R3");
      ac_frame(31, 31, -1, 1'b1, 2, "R2");
      ac_frame(17, 17, -1, 1'b0, 0, "R4");
      ac_frame(12, 6, -1, 1'b1, 0, "R9");
      ac_frame(1, 1, -1, 1'b1, 32, "R1");

      // R10: frame and request while a stalled reply is pending
      cur_req = "R10"; base = nbeats;
      hold_low = 1'b1;
      rx_req = 1'b1; @(negedge clk); rx_req = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 5; i++) put_bit(1'b0);
      for (int i = 0; i < 8; i++) put_bit(i[0]);
      rx_eof = 1'b1; rx_crc_ok = 1'b1; @(negedge clk); rx_eof = 1'b0; rx_crc_ok = 1'b0;
      rx_req = 1'b1; @(negedge clk); rx_req = 1'b0;
      chk(tx_valid && tx_sof, "R10", "reply still at sof", int'({tx_valid, tx_sof}), 3);
      hold_low = 1'b0;
      wait_idle();
      chk(nbeats - base == 33, "R10", "only first reply sent", nbeats - base, 33);
      ac_frame(4, 4, -1, 1'b1, 29, "R10");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule